// File: doc/BRIEF.md
# Write-Once Snoopy Coherence Controller

This block is the coherence controller that sits beside one private cache in a shared-bus multiprocessor. It holds a small direct-mapped array of one-word lines. Each line carries a tag, a data word and one of four coherence states: invalid, valid, reserved or dirty. The processor side issues one read or write at a time. The controller either completes the access locally or takes the shared bus to fetch, invalidate, write through or write back.

The protocol is write-once. The first write to a shared (valid) line goes through to memory and invalidates every other copy, which leaves the line reserved. A later write to a reserved line stays local and makes it dirty. Only a dirty line supplies data to other caches in place of memory, and only a dirty line is written back when it is replaced.

At the same time the controller snoops the commands that other caches place on the bus. It answers in the same cycle with a hit flag and, when its copy is dirty, with a memory-inhibit flag and the data word. Two or more instances share one bus, one grant arbiter and one memory.

Top module: `wo_coh_ctrl`

## Requirements
- R1: After reset every line is invalid and `cpu_busy_o` is low, so the first access to any address misses and uses the bus.
- R2: A processor read that hits completes with `cpu_done_o` one cycle after acceptance. The data is taken from the local array, and no bus request is made.
- R3: A read miss issues command READ (code 1) at the missed address. The returned word comes from a remote cache when that cache raises inhibit, and from memory otherwise. The line ends valid.
- R4: A snooped READ that hits a dirty line raises `snp_hit_o` and `snp_inh_o` and puts the line's word on `snp_data_o` in the same cycle. A snooped READ that hits a dirty or reserved line leaves that line valid, so the next local write goes to the bus again.
- R5: A write hit on a reserved or dirty line completes with no bus traffic and leaves the line dirty. Memory is not written.
- R6: A write hit on a valid line issues command WINV (code 3). WINV carries the new word, which memory stores, and invalidates every other copy. The line becomes reserved.
- R7: A write miss issues command RDINV (code 2), which invalidates every other copy. The line ends dirty and holds the written word.
- R8: When a miss selects a dirty victim, command WB (code 4) with the victim's address and word comes first, and the fill follows it. A victim that is valid, reserved or invalid causes no WB.
- R9: A snooped RDINV or WINV whose tag matches moves the line to invalid. If that line was dirty, it first raises inhibit and supplies its word in that cycle.
- R10: `cpu_busy_o` is high while a bus transaction is pending, and `cpu_done_o` is never high with it. No new request is accepted while another cache's command is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_i | input | 1 | Processor request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 8 | Word address: upper 6 bits are the tag, lower 2 bits are the line index |
| cpu_wdata_i | input | 16 | Write word |
| cpu_rdata_o | output | 16 | Read word, valid with cpu_done_o |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_busy_o | output | 1 | Bus transaction pending |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant; the command completes in the granted cycle |
| bus_cmd_o | output | 3 | 0 none, 1 READ, 2 RDINV, 3 WINV, 4 WB |
| bus_addr_o | output | 8 | Command address |
| bus_wdata_o | output | 16 | Word for WINV and WB |
| bus_rdata_i | input | 16 | Word returned for READ or RDINV in the granted cycle |
| snp_valid_i | input | 1 | Another cache's command is on the bus |
| snp_cmd_i | input | 3 | Snooped command code |
| snp_addr_i | input | 8 | Snooped address |
| snp_hit_o | output | 1 | Snooped address is held here |
| snp_inh_o | output | 1 | Dirty copy here: memory must not answer |
| snp_data_o | output | 16 | Word supplied for a dirty snoop hit |

## Verification
Line states cannot be read out, so a wrong state shows up only through the next access to that line. A line left reserved after a snooped read turns the next local write into silent traffic where a WINV was due. A line left valid after a snooped invalidate turns the next local read into a hit where a READ was due. A dirty line that wrongly lost its state surfaces as a missing inhibit or a missing WB. Every such fault appears on the bus command trace or the read word of the very next operation on the same index. The bench therefore follows each state-changing step with a probing access and compares the command sequence and data.

// File: rtl/wo_pkg.sv
package wo_pkg;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 2;
    localparam int DATA_W = 16;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int LINES  = 1 << IDX_W;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_VAL = 2'd1,
        LS_RES = 2'd2,
        LS_DRT = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        BC_NONE  = 3'd0,
        BC_READ  = 3'd1,
        BC_RDINV = 3'd2,
        BC_WINV  = 3'd3,
        BC_WB    = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WB   = 2'd1,
        S_BUS  = 2'd2
    } seq_st_e;

    typedef struct packed {
        line_st_e            st;
        logic [TAG_W-1:0]    tag;
        logic [DATA_W-1:0]   data;
    } line_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/wo_lines.sv
module wo_lines
    import wo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] cpu_idx,
    output line_t            cpu_line,
    input  logic [IDX_W-1:0] snp_idx,
    output line_t            snp_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_line,
    input  logic             snp_upd,
    input  line_st_e         snp_st
);
    line_t lines [LINES];

    assign cpu_line = lines[cpu_idx];
    assign snp_line = lines[snp_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                lines[i] <= '0;
            end
        end else begin
            if (snp_upd) begin
                lines[snp_idx].st <= snp_st;
            end
            if (wr_en) begin
                lines[wr_idx] <= wr_line;
            end
        end
    end

    // R9
    no_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && snp_upd) |-> (wr_idx != snp_idx));
endmodule

// File: rtl/wo_snoop.sv
module wo_snoop
    import wo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  line_t             snp_line,
    output logic              snp_hit,
    output logic              snp_inh,
    output logic [DATA_W-1:0] snp_data,
    output logic              snp_upd,
    output line_st_e          snp_st
);
    logic cmd_rd, cmd_inv, match;

    always_comb begin
        cmd_rd   = (snp_cmd == BC_READ);
        cmd_inv  = (snp_cmd == BC_RDINV) || (snp_cmd == BC_WINV);
        match    = snp_valid && (cmd_rd || cmd_inv) &&
                   (snp_line.st != LS_INV) && (snp_line.tag == tag_of(snp_addr));
        snp_hit  = match;
        snp_inh  = match && (snp_line.st == LS_DRT);
        snp_data = snp_line.data;
        snp_upd  = 1'b0;
        snp_st   = snp_line.st;
        if (match && cmd_inv) begin
            snp_upd = 1'b1;
            snp_st  = LS_INV;
        end else if (match && cmd_rd &&
                     (snp_line.st == LS_RES || snp_line.st == LS_DRT)) begin
            snp_upd = 1'b1;
            snp_st  = LS_VAL;
        end
    end

    // R4
    inh_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
        snp_inh |-> (snp_hit && snp_valid));
endmodule

// File: rtl/wo_seq.sv
module wo_seq
    import wo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              cpu_done_o,
    output logic              cpu_busy_o,
    input  logic              snp_valid_i,
    output logic [IDX_W-1:0]  look_idx,
    input  line_t             line_i,
    output logic              wr_en,
    output line_t             wr_line,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output bus_cmd_e          bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    seq_st_e            st_q;
    bus_cmd_e           cmd_q;
    logic               lat_we;
    logic [ADDR_W-1:0]  lat_addr;
    logic [DATA_W-1:0]  lat_wdata;
    logic [DATA_W-1:0]  rdata_q;
    logic               done_q;
    logic [TAG_W-1:0]   cur_tag;
    logic               hit, accept, own_wr;

    always_comb begin
        look_idx = (st_q == S_IDLE) ? idx_of(cpu_addr_i) : idx_of(lat_addr);
        cur_tag  = (st_q == S_IDLE) ? tag_of(cpu_addr_i) : tag_of(lat_addr);
        hit      = (line_i.st != LS_INV) && (line_i.tag == cur_tag);
        accept   = (st_q == S_IDLE) && cpu_req_i && !snp_valid_i;
        own_wr   = (line_i.st == LS_RES) || (line_i.st == LS_DRT);
    end

    always_comb begin
        wr_en       = 1'b0;
        wr_line     = '0;
        bus_req_o   = 1'b0;
        bus_cmd_o   = BC_NONE;
        bus_addr_o  = lat_addr;
        bus_wdata_o = lat_wdata;
        case (st_q)
            S_IDLE: begin
                if (accept && cpu_we_i && hit && own_wr) begin
                    wr_en   = 1'b1;
                    wr_line = '{st: LS_DRT, tag: cur_tag, data: cpu_wdata_i};
                end
            end
            S_WB: begin
                if (line_i.st == LS_DRT) begin
                    bus_req_o   = 1'b1;
                    bus_cmd_o   = BC_WB;
                    bus_addr_o  = {line_i.tag, look_idx};
                    bus_wdata_o = line_i.data;
                    wr_en       = bus_gnt_i;
                end
            end
            S_BUS: begin
                bus_req_o = 1'b1;
                bus_cmd_o = cmd_q;
                wr_en     = bus_gnt_i;
                case (cmd_q)
                    BC_READ:  wr_line = '{st: LS_VAL, tag: cur_tag, data: bus_rdata_i};
                    BC_RDINV: wr_line = '{st: LS_DRT, tag: cur_tag, data: lat_wdata};
                    default:  wr_line = '{st: LS_RES, tag: cur_tag, data: lat_wdata};
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            cmd_q     <= BC_NONE;
            lat_we    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rdata_q   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (accept) begin
                        lat_we    <= cpu_we_i;
                        lat_addr  <= cpu_addr_i;
                        lat_wdata <= cpu_wdata_i;
                        if (hit && !cpu_we_i) begin
                            rdata_q <= line_i.data;
                            done_q  <= 1'b1;
                        end else if (hit && own_wr) begin
                            done_q <= 1'b1;
                        end else if (hit) begin
                            cmd_q <= BC_WINV;
                            st_q  <= S_BUS;
                        end else begin
                            cmd_q <= cpu_we_i ? BC_RDINV : BC_READ;
                            st_q  <= (line_i.st == LS_DRT) ? S_WB : S_BUS;
                        end
                    end
                end
                S_WB: begin
                    if (line_i.st != LS_DRT || bus_gnt_i) begin
                        st_q <= S_BUS;
                    end
                end
                S_BUS: begin
                    if (bus_gnt_i) begin
                        done_q <= 1'b1;
                        st_q   <= S_IDLE;
                        if (cmd_q == BC_READ) begin
                            rdata_q <= bus_rdata_i;
                        end else begin
                            rdata_q <= lat_wdata;
                        end
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign cpu_rdata_o = rdata_q;
    assign cpu_done_o  = done_q;
    assign cpu_busy_o  = (st_q != S_IDLE);

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done_o |-> !cpu_busy_o);

    // R10
    snoop_stall_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == S_IDLE) && cpu_req_i && snp_valid_i) |=> !cpu_done_o);

    // R8
    wb_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && bus_cmd_o == BC_WB) |->
        ((idx_of(bus_addr_o) == idx_of(lat_addr)) &&
         (tag_of(bus_addr_o) != tag_of(lat_addr)) && (cmd_q != BC_WINV)));
endmodule

// File: rtl/wo_coh_ctrl.sv
module wo_coh_ctrl
    import wo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              cpu_done_o,
    output logic              cpu_busy_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [2:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              snp_valid_i,
    input  logic [2:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              snp_hit_o,
    output logic              snp_inh_o,
    output logic [DATA_W-1:0] snp_data_o
);
    logic [IDX_W-1:0] look_idx;
    line_t            cpu_line, snp_line, wr_line;
    logic             wr_en, snp_upd;
    line_st_e         snp_st;
    bus_cmd_e         cmd_out;

    wo_lines lines_i (
        .clk      (clk),
        .rst      (rst),
        .cpu_idx  (look_idx),
        .cpu_line (cpu_line),
        .snp_idx  (idx_of(snp_addr_i)),
        .snp_line (snp_line),
        .wr_en    (wr_en),
        .wr_idx   (look_idx),
        .wr_line  (wr_line),
        .snp_upd  (snp_upd),
        .snp_st   (snp_st)
    );

    wo_snoop snoop_i (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid_i),
        .snp_cmd   (bus_cmd_e'(snp_cmd_i)),
        .snp_addr  (snp_addr_i),
        .snp_line  (snp_line),
        .snp_hit   (snp_hit_o),
        .snp_inh   (snp_inh_o),
        .snp_data  (snp_data_o),
        .snp_upd   (snp_upd),
        .snp_st    (snp_st)
    );

    wo_seq seq_i (
        .clk         (clk),
        .rst         (rst),
        .cpu_req_i   (cpu_req_i),
        .cpu_we_i    (cpu_we_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_rdata_o (cpu_rdata_o),
        .cpu_done_o  (cpu_done_o),
        .cpu_busy_o  (cpu_busy_o),
        .snp_valid_i (snp_valid_i),
        .look_idx    (look_idx),
        .line_i      (cpu_line),
        .wr_en       (wr_en),
        .wr_line     (wr_line),
        .bus_req_o   (bus_req_o),
        .bus_gnt_i   (bus_gnt_i),
        .bus_cmd_o   (cmd_out),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_rdata_i (bus_rdata_i)
    );

    assign bus_cmd_o = cmd_out;
endmodule

// File: tb/wo_coh_ctrl_tb_top.sv
`timescale 1ns/1ps
module wo_coh_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic        a_req, a_we, b_req, b_we;
    logic [7:0]  a_addr, b_addr;
    logic [15:0] a_wd, b_wd;
    logic [15:0] a_rd, b_rd;
    logic        a_done, a_busy, b_done, b_busy;
    logic        a_breq, b_breq, gnt_a, gnt_b;
    logic [2:0]  a_cmd, b_cmd;
    logic [7:0]  a_baddr, b_baddr;
    logic [15:0] a_bwd, b_bwd, a_brd, b_brd;
    logic        a_hit, a_inh, b_hit, b_inh;
    logic [15:0] a_sd, b_sd;
    logic [15:0] mem [256];

    logic [2:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wd, bus_sup;
    logic        bus_inh;

    function automatic logic [15:0] init_word(input logic [7:0] a);
        return 16'hA000 | {8'h00, a};
    endfunction

    assign gnt_a    = a_breq;
    assign gnt_b    = b_breq && !a_breq;
    assign bus_cmd  = gnt_a ? a_cmd   : (gnt_b ? b_cmd   : 3'd0);
    assign bus_addr = gnt_a ? a_baddr : b_baddr;
    assign bus_wd   = gnt_a ? a_bwd   : b_bwd;
    assign bus_inh  = (gnt_a && b_inh) || (gnt_b && a_inh);
    assign bus_sup  = gnt_a ? b_sd : a_sd;
    assign a_brd    = b_inh ? b_sd : mem[a_baddr];
    assign b_brd    = a_inh ? a_sd : mem[b_baddr];

    wo_coh_ctrl dut_i (
        .clk(clk), .rst(rst),
        .cpu_req_i(a_req), .cpu_we_i(a_we), .cpu_addr_i(a_addr), .cpu_wdata_i(a_wd),
        .cpu_rdata_o(a_rd), .cpu_done_o(a_done), .cpu_busy_o(a_busy),
        .bus_req_o(a_breq), .bus_gnt_i(gnt_a), .bus_cmd_o(a_cmd), .bus_addr_o(a_baddr),
        .bus_wdata_o(a_bwd), .bus_rdata_i(a_brd),
        .snp_valid_i(gnt_b), .snp_cmd_i(b_cmd), .snp_addr_i(b_baddr),
        .snp_hit_o(a_hit), .snp_inh_o(a_inh), .snp_data_o(a_sd)
    );

    wo_coh_ctrl peer_i (
        .clk(clk), .rst(rst),
        .cpu_req_i(b_req), .cpu_we_i(b_we), .cpu_addr_i(b_addr), .cpu_wdata_i(b_wd),
        .cpu_rdata_o(b_rd), .cpu_done_o(b_done), .cpu_busy_o(b_busy),
        .bus_req_o(b_breq), .bus_gnt_i(gnt_b), .bus_cmd_o(b_cmd), .bus_addr_o(b_baddr),
        .bus_wdata_o(b_bwd), .bus_rdata_i(b_brd),
        .snp_valid_i(gnt_a), .snp_cmd_i(a_cmd), .snp_addr_i(a_baddr),
        .snp_hit_o(b_hit), .snp_inh_o(b_inh), .snp_data_o(b_sd)
    );

    // memory stub
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_word(8'(i));
        end else if (gnt_a || gnt_b) begin
            if (bus_cmd == 3'd3 || bus_cmd == 3'd4) mem[bus_addr] <= bus_wd;
            else if (bus_cmd == 3'd1 && bus_inh) mem[bus_addr] <= bus_sup;
        end
    end

    // bus trace
    int          n_tx = 0;
    logic [2:0]  log_cmd [16];
    logic [7:0]  log_addr [16];
    logic [15:0] log_wd [16];
    logic        log_inh [16];
    always @(negedge clk) begin
        if (!rst && (gnt_a || gnt_b)) begin
            log_cmd[n_tx[3:0]]  <= bus_cmd;
            log_addr[n_tx[3:0]] <= bus_addr;
            log_wd[n_tx[3:0]]   <= bus_wd;
            log_inh[n_tx[3:0]]  <= bus_inh;
            n_tx <= n_tx + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int          op_base, op_ntx;
    logic [15:0] op_rd;
    logic        op_busy;

    task automatic cpu_op(input logic side_b, input logic we, input logic [7:0] addr,
                          input logic [15:0] wd);
        int guard;
        @(negedge clk);
        op_base = n_tx;
        op_busy = 1'b0;
        if (side_b) begin b_req = 1; b_we = we; b_addr = addr; b_wd = wd; end
        else        begin a_req = 1; a_we = we; a_addr = addr; a_wd = wd; end
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (side_b ? b_busy : a_busy) op_busy = 1'b1;
            if (side_b ? b_done : a_done) break;
            if (guard > 40) begin
                chk(1'b0, "R10 op timeout", guard, 0);
                break;
            end
        end
        op_rd = side_b ? b_rd : a_rd;
        a_req = 0; b_req = 0;
        @(negedge clk);
        op_ntx = n_tx - op_base;
    endtask

    function automatic logic [3:0] li(input int k);
        return 4'(op_base + k);
    endfunction

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(!a_busy && !a_done && !a_breq, "R1 idle after reset", {a_busy, a_done}, 0);
        cpu_op(0, 0, 8'h10, 0);
        chk(op_ntx == 1 && log_cmd[li(0)] == 3'd1, "R1 first read misses", op_ntx, 1);
        chk(op_rd == 16'hA010, "R3 read miss from memory", op_rd, 16'hA010);
        chk(op_busy, "R10 busy during miss", op_busy, 1);
    endtask

    task automatic t_read_hit();
        cpu_op(0, 0, 8'h10, 0);
        chk(op_ntx == 0, "R2 read hit no bus", op_ntx, 0);
        chk(op_rd == 16'hA010 && !op_busy, "R2 read hit data", op_rd, 16'hA010);
    endtask

    task automatic t_write_through();
        cpu_op(0, 1, 8'h10, 16'h1111);
        chk(op_ntx == 1 && log_cmd[li(0)] == 3'd3, "R6 write hit valid issues WINV",
            log_cmd[li(0)], 3);
        chk(mem[8'h10] == 16'h1111, "R6 write-through to memory", mem[8'h10], 16'h1111);
    endtask

    task automatic t_local_write();
        cpu_op(0, 1, 8'h10, 16'h2222);
        chk(op_ntx == 0, "R5 reserved write stays local", op_ntx, 0);
        chk(mem[8'h10] == 16'h1111, "R5 memory untouched", mem[8'h10], 16'h1111);
        cpu_op(0, 0, 8'h10, 0);
        chk(op_ntx == 0 && op_rd == 16'h2222, "R5 local data", op_rd, 16'h2222);
    endtask

    task automatic t_dirty_supply();
        cpu_op(1, 0, 8'h10, 0);
        chk(op_ntx == 1 && log_inh[li(0)], "R4 dirty holder inhibits", log_inh[li(0)], 1);
        chk(op_rd == 16'h2222, "R3 data from remote dirty", op_rd, 16'h2222);
        cpu_op(0, 1, 8'h10, 16'h3333);
        chk(op_ntx == 1 && log_cmd[li(0)] == 3'd3, "R4 dirty dropped to valid",
            log_cmd[li(0)], 3);
    endtask

    task automatic t_snoop_inv();
        cpu_op(1, 0, 8'h10, 0);
        chk(op_ntx == 1 && !log_inh[li(0)], "R9 WINV invalidated peer", op_ntx, 1);
        chk(op_rd == 16'h3333, "R3 memory holds write-through", op_rd, 16'h3333);
        cpu_op(0, 1, 8'h10, 16'h4444);
        chk(op_ntx == 1 && log_cmd[li(0)] == 3'd3, "R4 reserved dropped to valid",
            log_cmd[li(0)], 3);
        cpu_op(1, 0, 8'h10, 0);
        chk(op_ntx == 1 && op_rd == 16'h4444, "R9 peer invalid again", op_rd, 16'h4444);
    endtask

    task automatic t_write_miss();
        cpu_op(0, 1, 8'h24, 16'h5555);
        chk(op_ntx == 1 && log_cmd[li(0)] == 3'd2 && log_addr[li(0)] == 8'h24,
            "R7 write miss RDINV", log_cmd[li(0)], 2);
        chk(op_ntx == 1, "R8 valid victim no WB", op_ntx, 1);
        cpu_op(0, 0, 8'h24, 0);
        chk(op_ntx == 0 && op_rd == 16'h5555, "R7 written word held", op_rd, 16'h5555);
        cpu_op(0, 1, 8'h24, 16'h6666);
        chk(op_ntx == 0, "R7 line dirty after miss", op_ntx, 0);
    endtask

    task automatic t_dirty_replace();
        cpu_op(0, 0, 8'h10, 0);
        chk(op_ntx == 2, "R8 two transactions", op_ntx, 2);
        chk(log_cmd[li(0)] == 3'd4 && log_addr[li(0)] == 8'h24 && log_wd[li(0)] == 16'h6666,
            "R8 WB first", log_wd[li(0)], 16'h6666);
        chk(log_cmd[li(1)] == 3'd1 && log_addr[li(1)] == 8'h10, "R8 fill second",
            log_cmd[li(1)], 1);
        chk(mem[8'h24] == 16'h6666 && op_rd == 16'h4444, "R8 memory updated", mem[8'h24],
            16'h6666);
    endtask

    task automatic t_rdinv_dirty();
        cpu_op(0, 1, 8'h31, 16'h7777);
        chk(op_ntx == 1 && log_cmd[li(0)] == 3'd2, "R7 miss RDINV", log_cmd[li(0)], 2);
        cpu_op(1, 1, 8'h31, 16'h8888);
        chk(op_ntx == 1 && log_cmd[li(0)] == 3'd2 && log_inh[li(0)],
            "R9 dirty supplies on RDINV", log_inh[li(0)], 1);
        cpu_op(0, 0, 8'h31, 0);
        chk(op_ntx == 1 && log_inh[li(0)], "R9 RDINV invalidated local", op_ntx, 1);
        chk(op_rd == 16'h8888, "R3 remote dirty word", op_rd, 16'h8888);
    endtask

    task automatic t_reset_again();
        do_reset();
        cpu_op(0, 0, 8'h31, 0);
        chk(op_ntx == 1 && op_rd == 16'hA031, "R1 reset invalidates lines", op_rd, 16'hA031);
    endtask

    initial begin
        #400000;
        chk(1'b0, "R10 watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        a_req = 0; a_we = 0; a_addr = 0; a_wd = 0;
        b_req = 0; b_we = 0; b_addr = 0; b_wd = 0;
        t_reset();
        t_read_hit();
        t_write_through();
        t_local_write();
        t_dirty_supply();
        t_snoop_inv();
        t_write_miss();
        t_dirty_replace();
        t_rdinv_dirty();
        t_reset_again();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule